// File: doc/BRIEF.md
# Multiplier-Feedback Event Divider

This block thins a stream of enable strobes by a power of two without a binary counter. A registered signed 9x9 multiplier sits in a feedback loop. On each enabled clock, its 18-bit product register takes the product of a fixed coefficient (131, one half plus three in 8-bit fixed point) and an operand built from the low bits of the previous product. The low bits of the product step through a full-length permutation. The output strobe fires when the register holds the single terminal state of that cycle, which is recognised from two product bits.

A compile-time parameter picks a period of 256 enabled cycles (8-bit mode) or 128 enabled cycles (7-bit mode). The raw product is exported. Its low byte is also exported as a pseudo-random byte, because no value repeats within one period.

Top module: `mulfb_event_div`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the product register is cleared to zero. As a result, `prod_word`, `rand_byte` and `div_strobe` read zero in the following cycle.
- R2: With `rst_n` high and `step_en` low at a rising edge, `prod_word` keeps its value.
- R3: With `rst_n` and `step_en` both high at a rising edge, the new `prod_word` is the signed 18-bit product of 131 and a 9-bit operand. That operand is the low DIV_BITS bits of the current product with bit 0 inverted, zero-extended to 9 bits. DIV_BITS is 8 or 7.
- R4: `div_strobe` is `step_en` AND two product bits, both combinational. In 8-bit mode the bits are 15 and 9; in 7-bit mode they are 14 and 7. The strobe is therefore high only in state 0x827D (8-bit mode) or state 0x40FD (7-bit mode).
- R5: Counting only cycles with `step_en` high, successive strobes are exactly 2^DIV_BITS enabled cycles apart. This holds whether the enable is continuous or gapped.
- R6: The 2^DIV_BITS product values visited in one period, starting after reset, are all distinct, and so are their low bytes.
- R7: `rand_byte` always equals bit 7 down to bit 0 of `prod_word`.
- R8: `div_strobe` is never high in a cycle where `step_en` is low.
- R9: Over one period, the count of states with the top decoded bit set is five in 8-bit mode (bit 15) and two in 7-bit mode (bit 14). Exactly one of them has the second decoded bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Enable strobe to be divided; advances the state |
| div_strobe | output | 1 | One-cycle divided strobe |
| prod_word | output | 18 | Registered multiplier product (state) |
| rand_byte | output | 8 | Low byte of the product, pseudo-random |

## Verification
Every cycle, assertions check four properties: reset clearing, hold while disabled, that each load equals the previous operand times 131, and that a strobe only appears together with the enable and the terminal state. The properties that span a whole period can only be shown by the bench scenarios. These are the 256- or 128-cycle spacing under continuous and gapped enables, the uniqueness of the visited states, and the census of states with the top decoded bit set. The bench runs both modes side by side against an arithmetic model of the iteration.

// File: rtl/mfd_pkg.sv
// Package: shared widths and mode-dependent bit positions for the
// multiplier-feedback event divider.
// Assumes DIV_BITS is 8 or 7; other values are not supported.
package mfd_pkg;
    localparam int OP_W      = 9;             // multiplier operand width
    localparam int PROD_W    = 2 * OP_W;      // product register width
    localparam int RAND_W    = 8;             // exported random byte width
    localparam int COEF_HALF = 1 << (OP_W - 2); // 0.5 in the operand's fixed point

    // Position of the upper decoded product bit for a given mode.
    function automatic int hi_pos(input int div_bits);
        return div_bits + 7;
    endfunction

    // Position of the lower decoded product bit for a given mode.
    function automatic int lo_pos(input int div_bits);
        return (div_bits == 8) ? 9 : 7;
    endfunction
endpackage

// File: rtl/mfd_operand.sv
// Module: builds the feedback operand from the low product bits.
// The operand is the low DIV_BITS product bits with bit 0 inverted,
// zero-extended to the multiplier width, so it is never negative.
// Assumes DIV_BITS < OP_W.
module mfd_operand #(
    parameter int DIV_BITS = 8,
    parameter int OP_W     = 9
) (
    input  logic [DIV_BITS-1:0] low_i,
    output logic [OP_W-1:0]     op_o
);
    localparam int PAD_W = OP_W - DIV_BITS;

    logic [DIV_BITS-1:0] flipped;

    // Invert the least significant bit, keep the rest.
    always_comb begin
        flipped    = low_i;
        flipped[0] = ~low_i[0];
    end

    // Zero-extend to the operand width.
    assign op_o = {{PAD_W{1'b0}}, flipped};
endmodule

// File: rtl/mfd_mulreg.sv
// Module: signed OP_W x OP_W multiplier with a registered product.
// Both operands are sign-extended to PROD_W before multiplying; the
// product register clears on synchronous active-low reset and loads
// only when en_i is high. Assumes PROD_W >= OP_W and PROD_W <= 32.
module mfd_mulreg #(
    parameter int              OP_W   = 9,
    parameter int              PROD_W = 18,
    parameter logic [OP_W-1:0] COEF   = 9'd131
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [PROD_W-1:0] prod_o
);
    localparam int EXT_W = PROD_W - OP_W;

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    logic signed [PROD_W-1:0] p_next;

    // Sign-extend both operands and form the full product.
    assign a_ext  = signed'({{EXT_W{op_i[OP_W-1]}}, op_i});
    assign b_ext  = signed'({{EXT_W{COEF[OP_W-1]}}, COEF});
    assign p_next = a_ext * b_ext;

    // Product register: reset clears, enable loads, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_o <= '0;
        end else if (en_i) begin
            prod_o <= p_next;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> prod_o == '0); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en_i |=> $stable(prod_o)); // R2
    AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n) (en_i && !op_i[OP_W-1]) |=> prod_o == PROD_W'(32'($past(op_i)) * 32'(COEF))); // R3
endmodule

// File: rtl/mfd_wrapdet.sv
// Module: terminal-state detector. Fires when both selected product
// bits are set in a cycle where the enable is high.
// Assumes the caller has selected the two bits that single out the
// terminal state of the current mode.
module mfd_wrapdet (
    input  logic hi_i,
    input  logic lo_i,
    input  logic en_i,
    output logic strobe_o
);
    // Three-input AND, combinational from the registered product.
    assign strobe_o = hi_i & lo_i & en_i;
endmodule

// File: rtl/mulfb_event_div.sv
// Module: multiplier-feedback event divider (top).
// Divides step_en by 2^DIV_BITS using a multiply-by-131 iteration on the
// low product bits, and exports the product and its low byte.
// Assumes DIV_BITS is 8 or 7 and step_en is synchronous to clk.
module mulfb_event_div
    import mfd_pkg::*;
#(
    parameter int DIV_BITS   = 8,
    parameter int COEF_DELTA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    output logic              div_strobe,
    output logic [PROD_W-1:0] prod_word,
    output logic [RAND_W-1:0] rand_byte
);
    localparam logic [OP_W-1:0]   COEF       = OP_W'(COEF_HALF + COEF_DELTA);
    localparam int                TERM_OP    = (1 << DIV_BITS) - 1;
    localparam logic [PROD_W-1:0] TERM_STATE = PROD_W'(TERM_OP * int'(COEF));
    localparam int                HI_POS     = hi_pos(DIV_BITS);
    localparam int                LO_POS     = lo_pos(DIV_BITS);

    logic [PROD_W-1:0] prod_q;
    logic [OP_W-1:0]   operand;
    logic              hi_bit;
    logic              lo_bit;

    // Feedback operand from the low product bits.
    mfd_operand #(
        .DIV_BITS(DIV_BITS),
        .OP_W    (OP_W)
    ) u_operand (
        .low_i(prod_q[DIV_BITS-1:0]),
        .op_o (operand)
    );

    // Registered multiplier holding the divider state.
    mfd_mulreg #(
        .OP_W  (OP_W),
        .PROD_W(PROD_W),
        .COEF  (COEF)
    ) u_mulreg (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (step_en),
        .op_i  (operand),
        .prod_o(prod_q)
    );

    // Pick the two decode bits for the selected mode.
    generate
        if (DIV_BITS == 8) begin : g_byte_mode
            assign hi_bit = prod_q[HI_POS];
            assign lo_bit = prod_q[LO_POS];
        end else begin : g_seven_mode
            assign hi_bit = prod_q[HI_POS];
            assign lo_bit = prod_q[LO_POS];
        end
    endgenerate

    // Terminal-state detector producing the divided strobe.
    mfd_wrapdet u_wrapdet (
        .hi_i    (hi_bit),
        .lo_i    (lo_bit),
        .en_i    (step_en),
        .strobe_o(div_strobe)
    );

    // Export the state and its low byte.
    assign prod_word = prod_q;
    assign rand_byte = prod_q[RAND_W-1:0];

    AST_STROBE_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n) div_strobe |-> prod_word == TERM_STATE); // R4
    AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) !step_en |-> !div_strobe); // R8
endmodule

// File: tb/mulfb_event_div_test.sv
// Bench: runs the 8-bit and 7-bit modes side by side against an
// arithmetic model of the multiply-by-131 iteration.
module mulfb_event_div_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        s8, s7;
    logic [17:0] p8, p7;
    logic [7:0]  r8, r7;

    int checks = 0;
    int errors = 0;

    logic [17:0] m8 = '0, m7 = '0;
    int  cnt8 = 0, cnt7 = 0, last8 = -1, last7 = -1, nstr8 = 0, nstr7 = 0;
    bit  seen8 [256];
    bit  seen7 [256];
    int  dist8 = 0, dist7 = 0, top8 = 0, top7 = 0, both8 = 0, both7 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mulfb_event_div #(.DIV_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .div_strobe(s8), .prod_word(p8), .rand_byte(r8)
    );

    mulfb_event_div #(.DIV_BITS(7)) uut7 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .div_strobe(s7), .prod_word(p7), .rand_byte(r7)
    );

    function automatic logic [17:0] model_next(input logic [17:0] p, input int n);
        int v;
        v = (int'(p) % (1 << n)) ^ 1;
        return 18'(v * 131);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input bit rst, input bit en, input bit collect);
        bit e8, e7;
        @(negedge clk);
        rst_n = rst;
        step_en = en;
        #1;
        chk(p8 == m8, en ? "R3 8-bit load" : "R2 8-bit hold", p8, m8);
        chk(p7 == m7, en ? "R3 7-bit load" : "R2 7-bit hold", p7, m7);
        chk(r8 == m8[7:0], "R7 8-bit rand", r8, m8[7:0]);
        chk(r7 == m7[7:0], "R7 7-bit rand", r7, m7[7:0]);
        e8 = en && m8[15] && m8[9];
        e7 = en && m7[14] && m7[7];
        if (!en) begin
            chk(!s8, "R8 8-bit strobe without enable", s8, 0);
            chk(!s7, "R8 7-bit strobe without enable", s7, 0);
        end else begin
            chk(s8 == e8, "R4 8-bit strobe decode", s8, e8);
            chk(s7 == e7, "R4 7-bit strobe decode", s7, e7);
        end
        if (s8 && en) begin
            if (last8 >= 0) chk(cnt8 - last8 == 256, "R5 8-bit period", cnt8 - last8, 256);
            last8 = cnt8;
            nstr8++;
        end
        if (s7 && en) begin
            if (last7 >= 0) chk(cnt7 - last7 == 128, "R5 7-bit period", cnt7 - last7, 128);
            last7 = cnt7;
            nstr7++;
        end
        if (collect && cnt8 >= 1 && cnt8 <= 256) begin
            if (!seen8[p8[7:0]]) dist8++;
            seen8[p8[7:0]] = 1'b1;
            if (p8[15]) top8++;
            if (p8[15] && p8[9]) both8++;
        end
        if (collect && cnt7 >= 1 && cnt7 <= 128) begin
            if (!seen7[p7[7:0]]) dist7++;
            seen7[p7[7:0]] = 1'b1;
            if (p7[14]) top7++;
            if (p7[14] && p7[7]) both7++;
        end
        @(posedge clk);
        if (!rst) begin
            m8 = '0; m7 = '0; cnt8 = 0; cnt7 = 0; last8 = -1; last7 = -1;
        end else if (en) begin
            m8 = model_next(m8, 8);
            m7 = model_next(m7, 7);
            cnt8++;
            cnt7++;
        end
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        #1;
        chk(p8 == 0 && r8 == 0 && !s8, "R1 8-bit reset state", p8, 0);
        chk(p7 == 0 && r7 == 0 && !s7, "R1 7-bit reset state", p7, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset with the enable high: it must not advance the state.
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
        check_reset_state();

        // Continuous enable over three 8-bit periods.
        for (int i = 0; i < 3 * 256; i++) step(1'b1, 1'b1, 1'b1);
        chk(dist8 == 256, "R6 8-bit distinct states", dist8, 256);
        chk(dist7 == 128, "R6 7-bit distinct states", dist7, 128);
        chk(top8 == 5, "R9 8-bit bit-15 census", top8, 5);
        chk(both8 == 1, "R9 8-bit terminal count", both8, 1);
        chk(top7 == 2, "R9 7-bit bit-14 census", top7, 2);
        chk(both7 == 1, "R9 7-bit terminal count", both7, 1);

        // Gapped enable: holds and strobe suppression between steps.
        for (int i = 0; i < 1500; i++) step(1'b1, (i % 3) != 1, 1'b0);

        // Mid-run reset, then restart from the cleared state.
        for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0);
        check_reset_state();
        for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1'b0);

        chk(nstr8 >= 5, "R5 8-bit strobes seen", nstr8, 5);
        chk(nstr7 >= 10, "R5 7-bit strobes seen", nstr7, 10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule